// File: doc/BRIEF.md
# Crosspoint Port Configuration I2C Target

This block is the configuration front end of a clock crosspoint switch. It is a target on a two-wire I2C bus and holds one 8-bit configuration byte for each port of the switch. A host selects the block by its 7-bit address, then either writes a run of bytes into the registers or reads a run of bytes back. Every transfer begins at register 0 and moves up one register per byte. The register contents also drive a flat parallel bus, which the crosspoint datapath decodes for each port.

The bus wires are brought into a fast system clock through two-flop synchronisers. The system clock must run at least 16 times faster than SCL, which covers SCL rates up to 400 kHz. START and STOP conditions are detected from SDA edges while SCL is high. The block drives SDA only through an open-drain pull-low output. It pulls SDA low for its acknowledge bits and for the 0 bits of read data, and releases SDA at all other times. An active-low asynchronous reset clears every register to 0x00.

Top module: `xcfg_i2c_target`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal binary 10110 followed by strap_i[1] and then strap_i[0]. After a non-matching address it never pulls SDA low before the next START, and it changes no register.
- R2: In a write transfer, data bytes are received MSB first. The first data byte after the address goes to register 0, and each later byte goes to the next register up.
- R3: In a read transfer (R/W bit = 1), the block returns register contents MSB first, starting at register 0 and moving up one register after each byte that the host acknowledges.
- R4: Every START, including a repeated START with no STOP before it, sets the byte index back to register 0.
- R5: Once all sixteen registers have been written in a transfer, any further write byte is not acknowledged (SDA stays high in its ACK slot) and changes no register.
- R6: A read of a byte beyond register 15 returns 0xFF.
- R7: While rst_ni is low, every register is 0x00 and SDA is released.
- R8: cfg_o[8k+7:8k] always equals register k.
- R9: Each accepted write byte (bytes 0 to 15) is acknowledged by pulling SDA low during its ninth clock. The block changes its SDA drive only after a falling edge of SCL.
- R10: A STOP releases SDA and returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 16 times the SCL rate |
| rst_ni | input | 1 | Asynchronous active-low master reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_low_o | output | 1 | High to pull SDA low (open drain) |
| strap_i | input | 2 | Address strap; bit 1 and bit 0 are the two low address bits |
| cfg_o | output | 8*NUM_REGS (128) | All configuration registers; register k in bits [8k+7:8k] |

## Verification
The assertions check on every cycle the properties that do not depend on the order of a transfer. A register write never targets an index past the map. The parallel bus changes only in the cycle after a write strobe. The byte index is zero after each START. The pull-low output starts only after an SCL falling edge and is released after a STOP. Only the bench scenarios can show the behaviour that depends on sequence: that address matching follows the strap pins across all sixteen strap and address pairs, that bytes land in and return from consecutive registers MSB first, that extra writes are refused, that reads past the map return 0xFF, and that a repeated START restarts at register 0.

// File: rtl/xcfg_pkg.sv
package xcfg_pkg;
  localparam int BYTE_W = 8;
  localparam logic [4:0] ADDR_PREFIX = 5'b10110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } tgt_state_e;
endpackage

// File: rtl/xcfg_bus_sync.sv
module xcfg_bus_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  // one extra stage past the synchroniser holds the previous value for edge detect
  localparam int LAST = SYNC_STAGES;

  logic [LAST:0] scl_ff, sda_ff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
    end else begin
      scl_ff <= {scl_ff[LAST-1:0], scl_i};
      sda_ff <= {sda_ff[LAST-1:0], sda_i};
    end
  end

  logic scl_now, scl_prev, sda_now, sda_prev;
  assign scl_now  = scl_ff[LAST-1];
  assign scl_prev = scl_ff[LAST];
  assign sda_now  = sda_ff[LAST-1];
  assign sda_prev = sda_ff[LAST];

  assign sda_o      = sda_now;
  assign scl_rise_o = scl_now & ~scl_prev;
  assign scl_fall_o = ~scl_now & scl_prev;
  assign start_o    = scl_now & scl_prev & sda_prev & ~sda_now;
  assign stop_o     = scl_now & scl_prev & ~sda_prev & sda_now;
endmodule

// File: rtl/xcfg_regfile.sv
module xcfg_regfile #(
  parameter int NUM_REGS = 16,
  parameter int IDX_W    = 5
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [IDX_W-1:0]      widx_i,
  input  logic [7:0]            wdata_i,
  input  logic [IDX_W-1:0]      ridx_i,
  output logic [7:0]            rdata_o,
  output logic [NUM_REGS*8-1:0] cfg_o
);
  logic [7:0] regs [NUM_REGS];

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               regs[k] <= '0;
      else if (we_i && widx_i == IDX_W'(k))      regs[k] <= wdata_i;
    end
    assign cfg_o[8*k +: 8] = regs[k];
  end

  // out-of-map index reads as all ones
  always_comb begin
    rdata_o = 8'hFF;
    for (int k = 0; k < NUM_REGS; k++)
      if (ridx_i == IDX_W'(k)) rdata_o = regs[k];
  end
endmodule

// File: rtl/xcfg_proto_fsm.sv
module xcfg_proto_fsm
  import xcfg_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int IDX_W    = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             sda_i,
  input  logic [6:0]       addr_i,
  input  logic [7:0]       rdata_i,
  output logic             sda_low_o,
  output logic             we_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [7:0]       wdata_o,
  output logic             busy_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS);

  tgt_state_e       state;
  logic [7:0]       sh;
  logic [3:0]       cnt;
  logic [IDX_W-1:0] idx;
  logic             rw, acked, sda_low;

  logic in_map;
  assign in_map = idx < LAST_IDX;

  assign we_o      = (state == ST_WR) && scl_fall_i && (cnt == 4'd8) && in_map;
  assign wdata_o   = sh;
  assign idx_o     = idx;
  assign sda_low_o = sda_low;
  assign busy_o    = state != ST_IDLE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= ST_IDLE;
      sh      <= '0;
      cnt     <= '0;
      idx     <= '0;
      rw      <= 1'b0;
      acked   <= 1'b0;
      sda_low <= 1'b0;
    end else if (start_i) begin
      state   <= ST_ADDR;
      cnt     <= '0;
      idx     <= '0;
      sda_low <= 1'b0;
    end else if (stop_i) begin
      state   <= ST_IDLE;
      sda_low <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_ADDR: begin
          if (scl_rise_i) begin
            sh  <= {sh[6:0], sda_i};
            cnt <= cnt + 4'd1;
          end else if (scl_fall_i && cnt == 4'd8) begin
            cnt <= '0;
            if (sh[7:1] == addr_i) begin
              rw      <= sh[0];
              sda_low <= 1'b1;
              state   <= ST_ADDR_ACK;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall_i) begin
            cnt <= '0;
            if (rw) begin
              sh      <= rdata_i;
              sda_low <= ~rdata_i[7];
              state   <= ST_RD;
            end else begin
              sda_low <= 1'b0;
              state   <= ST_WR;
            end
          end
        end
        ST_WR: begin
          if (scl_rise_i) begin
            sh  <= {sh[6:0], sda_i};
            cnt <= cnt + 4'd1;
          end else if (scl_fall_i && cnt == 4'd8) begin
            cnt     <= '0;
            acked   <= in_map;
            sda_low <= in_map;
            state   <= ST_WR_ACK;
          end
        end
        ST_WR_ACK: begin
          if (scl_fall_i) begin
            sda_low <= 1'b0;
            if (acked) idx <= idx + 1'b1;
            state <= ST_WR;
          end
        end
        ST_RD: begin
          if (scl_rise_i) begin
            cnt <= cnt + 4'd1;
          end else if (scl_fall_i) begin
            if (cnt == 4'd8) begin
              cnt     <= '0;
              sda_low <= 1'b0;
              state   <= ST_RD_ACK;
            end else begin
              sh      <= {sh[6:0], 1'b1};
              sda_low <= ~sh[6];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise_i) begin
            if (sda_i)       state <= ST_IDLE;  // host NACK ends the read
            else if (in_map) idx   <= idx + 1'b1;
          end else if (scl_fall_i) begin
            sh      <= rdata_i;
            sda_low <= ~rdata_i[7];
            state   <= ST_RD;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xcfg_i2c_target.sv
module xcfg_i2c_target
  import xcfg_pkg::*;
#(
  parameter int NUM_REGS    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_low_o,
  input  logic [1:0]            strap_i,
  output logic [NUM_REGS*8-1:0] cfg_o
);
  localparam int IDX_W = $clog2(NUM_REGS) + 1;

  logic             sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic             we, busy;
  logic [IDX_W-1:0] byte_idx;
  logic [7:0]       wdata, rdata;
  logic [6:0]       own_addr;

  assign own_addr = {ADDR_PREFIX, strap_i};

  xcfg_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o     (sda_s),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_det),
    .stop_o    (stop_det)
  );

  xcfg_proto_fsm #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_fsm (
    .clk_i, .rst_ni,
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .start_i   (start_det),
    .stop_i    (stop_det),
    .sda_i     (sda_s),
    .addr_i    (own_addr),
    .rdata_i   (rdata),
    .sda_low_o (sda_low_o),
    .we_o      (we),
    .idx_o     (byte_idx),
    .wdata_o   (wdata),
    .busy_o    (busy)
  );

  xcfg_regfile #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i   (we),
    .widx_i (byte_idx),
    .wdata_i(wdata),
    .ridx_i (byte_idx),
    .rdata_o(rdata),
    .cfg_o  (cfg_o)
  );
endmodule

// File: rtl/xcfg_i2c_chk.sv
module xcfg_i2c_chk #(
  parameter int NUM_REGS = 16,
  parameter int IDX_W    = 5
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  we,
  input logic [IDX_W-1:0]      byte_idx,
  input logic                  start_det,
  input logic                  stop_det,
  input logic                  scl_fall,
  input logic                  busy,
  input logic                  sda_low_o,
  input logic [NUM_REGS*8-1:0] cfg_o
);
  // R5
  wr_in_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we |-> byte_idx < IDX_W'(NUM_REGS));

  // R8
  cfg_only_on_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_o) |-> $past(we));

  // R4
  start_resets_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> byte_idx == '0);

  // R9
  drive_after_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_low_o) |-> $past(scl_fall));

  // R10
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_low_o && !busy);
endmodule

bind xcfg_i2c_target xcfg_i2c_chk #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_chk (
  .clk_i, .rst_ni, .we, .byte_idx, .start_det, .stop_det,
  .scl_fall, .busy, .sda_low_o, .cfg_o
);

// File: tb/xcfg_i2c_target_tb.sv
module xcfg_i2c_target_tb;
  localparam int N = 16;
  localparam int Q = 10;  // quarter SCL period in system clocks

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic scl = 1'b1;
  logic host_sda = 1'b1;
  logic [1:0] strap = 2'b00;
  logic sda_low;
  logic [N*8-1:0] cfg;
  logic sda_line;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  assign sda_line = host_sda & ~sda_low;

  xcfg_i2c_target u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl), .sda_i(sda_line),
    .sda_low_o(sda_low), .strap_i(strap), .cfg_o(cfg)
  );

  task automatic wt(input int c);
    repeat (c) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    host_sda = 1'b1; wt(Q); scl = 1'b1; wt(Q);
    host_sda = 1'b0; wt(Q); scl = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; wt(Q); scl = 1'b1; wt(Q); host_sda = 1'b1; wt(2*Q);
  endtask

  task automatic put_bit(input bit b);
    host_sda = b; wt(Q); scl = 1'b1; wt(2*Q); scl = 1'b0; wt(Q);
  endtask

  // returns 1 when the target acknowledged
  task automatic put_byte(input logic [7:0] d, output bit ack);
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    host_sda = 1'b1; wt(Q); scl = 1'b1; wt(Q);
    ack = ~sda_line; wt(Q); scl = 1'b0; wt(Q);
  endtask

  task automatic get_byte(input bit last, output logic [7:0] d);
    host_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(Q); scl = 1'b1; wt(Q); d[i] = sda_line; wt(Q); scl = 1'b0;
    end
    wt(Q);
    put_bit(last);
    host_sda = 1'b1;
  endtask

  function automatic logic [7:0] pat(input int i, input int seed);
    return 8'((i * 29 + seed * 11 + 7) ^ 8'h5A);
  endfunction

  function automatic logic [6:0] own(input logic [1:0] s);
    return {5'b10110, s};
  endfunction

  initial begin
    bit ack;
    logic [7:0] d;
    logic [N*8-1:0] snap;

    wt(4);
    // R7 reset state
    check(cfg == '0, "R7 regs zero in reset", int'(cfg[31:0]), 0);
    check(sda_low == 1'b0, "R7 sda released in reset", int'(sda_low), 0);
    rst_ni = 1'b1; wt(4);

    // R1 address sweep over every strap and low-address pair
    for (int s = 0; s < 4; s++) begin
      strap = 2'(s);
      for (int a = 0; a < 4; a++) begin
        bus_start();
        put_byte({5'b10110, 2'(a), 1'b0}, ack);
        check(ack == (a == s), "R1 address match", int'(ack), int'(a == s));
        bus_stop();
      end
      bus_start();
      put_byte({5'b00110, 2'(s), 1'b0}, ack);
      check(!ack, "R1 wrong prefix NACK", int'(ack), 0);
      bus_stop();
    end

    strap = 2'b10;
    // R2/R9/R5 write the whole map, then one byte beyond it
    bus_start();
    put_byte({own(strap), 1'b0}, ack);
    for (int i = 0; i < N; i++) begin
      put_byte(pat(i, 1), ack);
      check(ack, "R9 data byte ACK", int'(ack), 1);
    end
    put_byte(8'hA5, ack);
    check(!ack, "R5 extra write NACK", int'(ack), 0);
    put_byte(8'h3C, ack);
    check(!ack, "R5 second extra write NACK", int'(ack), 0);
    bus_stop();
    check(sda_low == 1'b0, "R10 released after STOP", int'(sda_low), 0);
    for (int i = 0; i < N; i++)
      check(cfg[8*i +: 8] == pat(i, 1), "R2 R8 R5 register contents",
            int'(cfg[8*i +: 8]), int'(pat(i, 1)));

    // R3/R6 read back the map and two bytes past it
    bus_start();
    put_byte({own(strap), 1'b1}, ack);
    check(ack, "R3 read address ACK", int'(ack), 1);
    for (int i = 0; i < N + 2; i++) begin
      get_byte(i == N + 1, d);
      if (i < N) check(d == pat(i, 1), "R3 read data", int'(d), int'(pat(i, 1)));
      else       check(d == 8'hFF, "R6 read past map", int'(d), 8'hFF);
    end
    bus_stop();

    // R4 repeated START restarts at register 0
    bus_start();
    put_byte({own(strap), 1'b0}, ack);
    put_byte(8'h11, ack);
    put_byte(8'h22, ack);
    bus_start();
    put_byte({own(strap), 1'b0}, ack);
    put_byte(8'h33, ack);
    bus_stop();
    check(cfg[7:0] == 8'h33, "R4 reg0 after repeated START", int'(cfg[7:0]), 8'h33);
    check(cfg[15:8] == 8'h22, "R4 reg1 kept", int'(cfg[15:8]), 8'h22);
    check(cfg[23:16] == pat(2, 1), "R4 reg2 untouched", int'(cfg[23:16]), int'(pat(2, 1)));

    // R1 a transfer to another address changes nothing
    snap = cfg;
    bus_start();
    put_byte({own(2'b01), 1'b0}, ack);
    put_byte(8'hEE, ack);
    check(!ack, "R1 no ACK after foreign address", int'(ack), 0);
    put_byte(8'hEF, ack);
    bus_stop();
    check(cfg == snap, "R1 foreign write ignored", int'(cfg[31:0]), int'(snap[31:0]));

    // R7 reset clears a populated map
    rst_ni = 1'b0; wt(3);
    check(cfg == '0, "R7 regs cleared by reset", int'(cfg[31:0]), 0);
    rst_ni = 1'b1; wt(3);

    // R3 read after reset returns zero
    bus_start();
    put_byte({own(strap), 1'b1}, ack);
    get_byte(1'b1, d);
    bus_stop();
    check(d == 8'h00, "R3 R7 read after reset", int'(d), 0);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule